// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host with an 8-bit bus access to a bank of 64 sixteen-bit registers through four byte locations. Offset 0 is a control byte. It holds a 6-bit index that picks one wide register, a mode bit that is driven out on a pin, and a read-only ready flag. Offset 1 is an 8-bit interrupt status byte. Offsets 2 and 3 carry the low and high halves of the indexed register.

A host write of the low byte only loads a staging register. The wide register is written when the high byte arrives, and it receives the high byte together with the staged low byte. While the internal logic raises its busy input, the ready flag reads 0 and high-byte writes are dropped.

Offset 1 collects interrupt events. Seven of its bits are sticky and are cleared by writing 0. The lowest bit mirrors a live source. A single interrupt output is raised whenever any status bit is set. The internal logic reads the register bank through a separate read port.

Top module: `ixw_top`

## Requirements
- R1: A read of offset 0 returns the index in bits [5:0], the mode bit in bit 6 and the inverse of `busy` in bit 7, with `busy` taken at the read's clock edge. A write to offset 0 loads the index from bits [5:0] and the mode from bit 6. `pin_mode` always equals the stored mode bit.
- R2: `host_rdata` is loaded on a clock edge where `host_rd` is high. It holds its value on every other edge.
- R3: A write to offset 2 stores its byte in a staging register. A later write to offset 3 while `busy` is low writes {offset-3 byte, staged byte} into the indexed register. The staged byte is kept after the commit.
- R4: A write to offset 2 alone changes no wide register.
- R5: A write to offset 3 while `busy` is high changes no wide register. A write to offset 2 is still staged while `busy` is high.
- R6: Reads of offset 2 and offset 3 return the low and high half of the indexed register. They reflect every commit and index change made at least two clock edges before the read edge.
- R7: Status bits 7..1 are set by a one-cycle pulse on the matching `evt_in` bit and stay set afterwards. A host write to offset 1 clears each of these bits that is written as 0. Each bit written as 1 is left unchanged.
- R8: When an event on bits 7..1 arrives in the same cycle as a host write of 0 to that bit, the bit ends up set.
- R9: Status bit 0 equals `evt_in[0]` as sampled at the previous clock edge. Host writes have no effect on it.
- R10: `irq` is high exactly when any status bit is set, in the same cycle as the status.
- R11: After reset the index, the mode and all status bits are 0, and `irq` is 0. With `busy` high, offsets 0 and 1 then both read 0x00.
- R12: `core_rdata` returns the register selected by `core_raddr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Byte offset 0..3 |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| evt_in | input | 8 | Bits 7..1: event pulses; bit 0: live source level |
| busy | input | 1 | Internal logic cannot accept data |
| core_raddr | input | 6 | Internal read index |
| core_rdata | output | 16 | Internal read data, one cycle latency |
| irq | output | 1 | OR of all status bits |
| pin_mode | output | 1 | Stored mode bit |

## Verification
Control, status and staging writes take effect at the edge that samples the strobe. `host_rdata` changes at the edge that samples `host_rd`, so the bench reads it at the falling edge that follows. A commit reaches the offset 2 and 3 read path one edge after the write, and the read sampled on the next edge then returns it. Every bench read therefore starts at least two edges after the write it depends on, which the write and read tasks guarantee by always ending and starting on separate falling edges. Status and `irq` are due one edge after an event or a clearing write, and the core read port one edge after its address changes. The bench samples each of them at the next falling edge.

// File: rtl/ixw_pkg.sv
package ixw_pkg;
  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_STAT = 2'd1,
    OFS_DLO  = 2'd2,
    OFS_DHI  = 2'd3
  } ofs_e;

  localparam int unsigned BIT_READY = 7;
  localparam int unsigned BIT_MODE  = 6;
endpackage

// File: rtl/ixw_regfile.sv
module ixw_regfile #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, two synchronous read ports (read-before-write)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_a <= mem[ra_a];
    rd_b <= mem[ra_b];
  end
endmodule

// File: rtl/ixw_status.sv
module ixw_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] stat_q,
  output logic         irq_q
);
  logic [N-1:0] stat_d;

  // bit 0 follows its source; others are sticky, event beats a clear
  assign stat_d[0] = evt[0];
  for (genvar i = 1; i < N; i++) begin : g_sticky
    assign stat_d[i] = evt[i] | (stat_q[i] & ~(clr_we & ~clr_data[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end
endmodule

// File: rtl/ixw_host.sv
module ixw_host
  import ixw_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          host_addr,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [BYTE_W-1:0]   host_wdata,
  input  logic                busy,
  input  logic [BYTE_W-1:0]   stat_q,
  input  logic [2*BYTE_W-1:0] reg_q,
  output logic [BYTE_W-1:0]   host_rdata,
  output logic [IDX_W-1:0]    idx_q,
  output logic                mode_q,
  output logic                commit,
  output logic [2*BYTE_W-1:0] commit_data,
  output logic                stat_we
);
  ofs_e              ofs;
  logic              wr_ctrl;
  logic              wr_lo;
  logic [BYTE_W-1:0] stage_q;
  logic [BYTE_W-1:0] ctrl_view;
  logic [BYTE_W-1:0] rd_mux;

  assign ofs     = ofs_e'(host_addr);
  assign wr_ctrl = host_wr && (ofs == OFS_CTRL);
  assign wr_lo   = host_wr && (ofs == OFS_DLO);
  assign stat_we = host_wr && (ofs == OFS_STAT);
  assign commit  = host_wr && (ofs == OFS_DHI) && !busy;
  assign commit_data = {host_wdata, stage_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_ctrl) begin
      idx_q  <= host_wdata[IDX_W-1:0];
      mode_q <= host_wdata[BIT_MODE];
    end
  end

  // staging byte has no defined reset value
  always_ff @(posedge clk) begin
    if (wr_lo) stage_q <= host_wdata;
  end

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[IDX_W-1:0]   = idx_q;
    ctrl_view[BIT_MODE]    = mode_q;
    ctrl_view[BIT_READY]   = ~busy;
    unique case (ofs)
      OFS_CTRL: rd_mux = ctrl_view;
      OFS_STAT: rd_mux = stat_q;
      OFS_DLO:  rd_mux = reg_q[BYTE_W-1:0];
      default:  rd_mux = reg_q[2*BYTE_W-1:BYTE_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/ixw_top.sv
module ixw_top #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [7:0]       evt_in,
  input  logic             busy,
  input  logic [IDX_W-1:0] core_raddr,
  output logic [15:0]      core_rdata,
  output logic             irq,
  output logic             pin_mode
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = 2 * BYTE_W;

  logic [IDX_W-1:0] idx_q;
  logic             commit;
  logic [REG_W-1:0] commit_data;
  logic [REG_W-1:0] reg_q;
  logic             stat_we;
  logic [BYTE_W-1:0] stat_q;

  ixw_host #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_host (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .busy        (busy),
    .stat_q      (stat_q),
    .reg_q       (reg_q),
    .host_rdata  (host_rdata),
    .idx_q       (idx_q),
    .mode_q      (pin_mode),
    .commit      (commit),
    .commit_data (commit_data),
    .stat_we     (stat_we)
  );

  ixw_regfile #(.AW(IDX_W), .DW(REG_W)) u_regs (
    .clk   (clk),
    .we    (commit),
    .waddr (idx_q),
    .wdata (commit_data),
    .ra_a  (idx_q),
    .rd_a  (reg_q),
    .ra_b  (core_raddr),
    .rd_b  (core_rdata)
  );

  ixw_status #(.N(BYTE_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_in),
    .clr_we   (stat_we),
    .clr_data (host_wdata),
    .stat_q   (stat_q),
    .irq_q    (irq)
  );
endmodule

// File: rtl/ixw_checker.sv
module ixw_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] evt_in,
  input logic [7:0] status,
  input logic       irq,
  input logic       pin_mode
);
  // R11: reset leaves status, irq and mode at zero
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && !irq && !pin_mode));

  // R7: a set sticky bit survives any cycle without a status write
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == 2'd1) |=>
      ((status[7:1] & $past(status[7:1])) == $past(status[7:1])));

  // R7, R8: an event always leaves its bit set, even against a clear
  assert_event_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_in[7:1] != 7'd0) |=>
      ((status[7:1] & $past(evt_in[7:1])) == $past(evt_in[7:1])));

  // R9: bit 0 mirrors its source one edge later
  assert_live_bit_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (status[0] == $past(evt_in[0])));

  // R10: interrupt line matches the status contents
  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (status != 8'h00));

  // R1: mode only changes through a control write
  assert_mode_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == 2'd0) |=> $stable(pin_mode));
endmodule

bind ixw_top ixw_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .evt_in     (evt_in),
  .status     (stat_q),
  .irq        (irq),
  .pin_mode   (pin_mode)
);

// File: tb/tb_ixw_top.sv
`timescale 1ns/1ps
module tb_ixw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  host_addr = 2'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic [7:0]  evt_in = 8'h00;
  logic        busy = 1'b1;
  logic [5:0]  core_raddr = 6'd0;
  logic [15:0] core_rdata;
  logic        irq;
  logic        pin_mode;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  ixw_top dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_in(evt_in), .busy(busy), .core_raddr(core_raddr),
    .core_rdata(core_rdata), .irq(irq), .pin_mode(pin_mode)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse(input logic [7:1] m);
    @(negedge clk);
    evt_in[7:1] = m;
    @(negedge clk);
    evt_in[7:1] = 7'd0;
  endtask

  function automatic logic [15:0] pattern(input int i, input int pass);
    return 16'((i * 16'h0405) ^ 16'h5AA5 ^ (pass << 8) ^ (pass * 3));
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state with busy high
    rd(2'd0, d); chk("R11 ctrl", {8'h0, d}, 16'h0000);
    rd(2'd1, d); chk("R11 status", {8'h0, d}, 16'h0000);
    chk("R11 irq", {15'h0, irq}, 16'h0000);
    chk("R11 mode", {15'h0, pin_mode}, 16'h0000);
    busy = 1'b0;
    rd(2'd0, d); chk("R1 ready", {8'h0, d}, 16'h0080);

    // R1: index and mode sweep
    for (int i = 0; i < 64; i++) begin
      logic m;
      m = 1'(i & 1);
      wr(2'd0, {1'b0, m, 6'(i)});
      rd(2'd0, d); chk("R1 ctrl", {8'h0, d}, {8'h0, 1'b1, m, 6'(i)});
      chk("R1 pin_mode", {15'h0, pin_mode}, {15'h0, m});
    end

    // R3: fill the bank with pair writes, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 64; i++) begin
        logic [15:0] v;
        v = pattern(i, pass);
        wr(2'd0, 8'(i));
        wr(2'd2, v[7:0]);
        wr(2'd3, v[15:8]);
        model[i] = v;
      end
    end

    // R6: host readback, R12: core readback
    for (int i = 0; i < 64; i++) begin
      wr(2'd0, 8'(i));
      rd(2'd2, d); chk("R6 low", {8'h0, d}, {8'h0, model[i][7:0]});
      rd(2'd3, d); chk("R6 high", {8'h0, d}, {8'h0, model[i][15:8]});
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); core_raddr = 6'(i);
      @(negedge clk); chk("R12 core", core_rdata, model[i]);
    end

    // R4: low byte alone commits nothing
    wr(2'd0, 8'd5);
    wr(2'd2, 8'hEE);
    rd(2'd2, d); chk("R4 low", {8'h0, d}, {8'h0, model[5][7:0]});
    rd(2'd3, d); chk("R4 high", {8'h0, d}, {8'h0, model[5][15:8]});
    // R3: later high byte pairs with the staged low byte
    wr(2'd3, 8'h77); model[5] = 16'h77EE;
    rd(2'd2, d); chk("R3 staged low", {8'h0, d}, 16'h00EE);
    rd(2'd3, d); chk("R3 high", {8'h0, d}, 16'h0077);
    // R3: staged byte kept after commit
    wr(2'd3, 8'h78); model[5] = 16'h78EE;
    rd(2'd2, d); chk("R3 kept low", {8'h0, d}, 16'h00EE);

    // R5: busy drops the high byte, still stages the low byte
    @(negedge clk); busy = 1'b1;
    rd(2'd0, d); chk("R1 not ready", {8'h0, d}, 16'h0005);
    wr(2'd2, 8'h11);
    wr(2'd3, 8'h22);
    @(negedge clk); busy = 1'b0;
    rd(2'd2, d); chk("R5 low", {8'h0, d}, {8'h0, model[5][7:0]});
    rd(2'd3, d); chk("R5 high", {8'h0, d}, {8'h0, model[5][15:8]});
    wr(2'd3, 8'h33); model[5] = 16'h3311;
    rd(2'd2, d); chk("R5 staged while busy", {8'h0, d}, 16'h0011);
    @(negedge clk); core_raddr = 6'd5;
    @(negedge clk); chk("R12 after commit", core_rdata, 16'h3311);

    // R7, R10: each sticky bit
    for (int b = 1; b < 8; b++) begin
      logic [7:0] bit_m;
      bit_m = 8'(1 << b);
      pulse(bit_m[7:1]);
      rd(2'd1, d); chk("R7 set", {8'h0, d}, {8'h0, bit_m});
      chk("R10 irq high", {15'h0, irq}, 16'h0001);
      wr(2'd1, 8'hFF);
      rd(2'd1, d); chk("R7 write one keeps", {8'h0, d}, {8'h0, bit_m});
      wr(2'd1, ~bit_m);
      rd(2'd1, d); chk("R7 write zero clears", {8'h0, d}, 16'h0000);
      chk("R10 irq low", {15'h0, irq}, 16'h0000);
    end
    pulse(7'b1010101);
    rd(2'd1, d); chk("R7 multi", {8'h0, d}, 16'h00AA);
    wr(2'd1, 8'h0F);
    rd(2'd1, d); chk("R7 partial clear", {8'h0, d}, 16'h000A);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R7 full clear", {8'h0, d}, 16'h0000);

    // R8: event beats simultaneous clear
    for (int b = 1; b < 8; b++) begin
      logic [7:0] bit_m;
      bit_m = 8'(1 << b);
      @(negedge clk);
      evt_in[7:1] = bit_m[7:1];
      host_addr = 2'd1; host_wdata = 8'h00; host_wr = 1'b1;
      @(negedge clk);
      evt_in[7:1] = 7'd0; host_wr = 1'b0;
      rd(2'd1, d); chk("R8 event wins", {8'h0, d}, {8'h0, bit_m});
      wr(2'd1, 8'h00);
    end

    // R9: live bit 0
    @(negedge clk); evt_in[0] = 1'b1;
    rd(2'd1, d); chk("R9 follows source", {8'h0, d}, 16'h0001);
    chk("R10 irq from bit0", {15'h0, irq}, 16'h0001);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R9 write ignored", {8'h0, d}, 16'h0001);
    @(negedge clk); evt_in[0] = 1'b0;
    rd(2'd1, d); chk("R9 source low", {8'h0, d}, 16'h0000);
    chk("R10 irq clear", {15'h0, irq}, 16'h0000);

    // R2: read data holds without a strobe
    pulse(7'b0000011);
    rd(2'd1, held);
    @(negedge clk); host_addr = 2'd0;
    repeat (3) @(negedge clk);
    chk("R2 hold", {8'h0, host_rdata}, {8'h0, held});
    chk("R2 held value", {8'h0, held}, 16'h0006);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule